// File: doc/BRIEF.md
# Processor Hotplug Register Window

This block is a small register window through which firmware manages hot-added and hot-removed processors. The window is 12 bytes long and little-endian. Every access except the selector write goes through a 32-bit processor selector. A selector value of the processor count or above makes the whole window read as zero and ignore writes to its other registers. A selector value below the count gives access to that processor's status and control bits, and to the command machinery.

Hot-add and hot-remove request inputs, one bit per processor, raise per-processor event flags. Firmware clears these flags one processor at a time through a control byte. Firmware can also ask the window to find a processor with a pending event. A command write performs a single-cycle lowest-index search and moves the selector onto the processor it finds. Other commands return a 64-bit identity for the selected processor, or load two 32-bit status-report registers. The second of those loads pulses a notify output.

The bus has a write strobe. Write data is right-aligned, so byte registers take the low byte of the data. Read data is combinational on the current offset.

Top module: `hp_regwin`

## Requirements
- R1: At power-up the selector is 0. Reset (rst_n low) clears all per-processor flags, the command register and both report registers. Reset leaves the selector unchanged.
- R2: A write to offset 0x0 always loads the full 32-bit selector. The selector is valid when its value is below NCPU.
- R3: While the selector is invalid, every offset reads 0. Writes to offsets 0x4, 0x5 and 0x8 are ignored.
- R4: Offset 0x4 reads the status byte of the selected processor. Bit 0 is enabled, bit 1 is the insert event, bit 2 is the remove event, bit 4 is the firmware eject request, and all other bits are 0.
- R5: A hot-add request sets that processor's enabled and insert flags. A hot-remove request sets its remove flag. A request wins over a clear in the same cycle.
- R6: A control write to offset 0x4 affects only the selected processor. Bit 1 clears its insert flag and bit 2 clears its remove flag.
- R7: Control bit 4 sets the firmware eject request. Control bit 3 clears that request and, in the next cycle, gives a one-cycle pulse on `eject_pulse` at the selected processor's bit.
- R8: Command 0 is written as value 0 to offset 0x5. When any processor has an insert or remove flag set, it loads the selector with the lowest such index, visible from the next cycle. Under command 0, offset 0x8 reads the selector and offset 0x0 reads 0.
- R9: Command 0 with no pending event leaves the selector and all flags unchanged.
- R10: Under command 3, offset 0x8 reads the low 32 bits and offset 0x0 reads the high 32 bits of the selected processor's 64-bit ID.
- R11: Under command 1, a write to offset 0x8 loads `ost_event`. Under command 2, such a write loads `ost_status` and pulses `ost_notify` for one cycle in the next cycle.
- R12: Command values above 3 are ignored and the previous command stays in force. Writes to other offsets are ignored, and those offsets read 0. Under commands 1 and 2, offsets 0x0 and 0x8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| add_req | input | NCPU | Hot-add request per processor |
| rem_req | input | NCPU | Hot-remove request per processor |
| cpu_id | input | 64*NCPU | Packed 64-bit ID per processor, processor 0 in the low bits |
| eject_pulse | output | NCPU | One-cycle eject start per processor |
| ost_event | output | 32 | Status-report event register |
| ost_status | output | 32 | Status-report status register |
| ost_notify | output | 1 | One-cycle pulse after an ost_status load |

## Verification
The bench stages two pending processors and checks three things. The search must pick the lower index, not the last one raised. A control clear must touch only the selected processor; a decoder that ignored the selector would wipe a neighbour's pending flag. A search with nothing pending must leave a hand-written selector intact rather than zeroing it.

It also drives a hot-add in the same cycle as a clear of that processor, so a design that let the clear win would lose an event. It writes a selector equal to the processor count and checks two things: reads go to zero, and a blocked command write does not quietly change the command. It pulses reset after setting a non-zero selector, which catches a design that resets the selector.

// File: rtl/hp_pkg.sv
// Shared constants and types for the processor hotplug register window.
// Assumes a 4-bit byte offset and right-aligned write data.
package hp_pkg;
    localparam logic [3:0] OFF_SEL  = 4'h0;
    localparam logic [3:0] OFF_CTL  = 4'h4;
    localparam logic [3:0] OFF_CMD  = 4'h5;
    localparam logic [3:0] OFF_DATA = 4'h8;

    localparam int ID_W = 64;

    // Status byte bit positions
    localparam int ST_EN   = 0;
    localparam int ST_INS  = 1;
    localparam int ST_REM  = 2;
    localparam int ST_FWEJ = 4;

    // Control byte bit positions
    localparam int CT_CLR_INS = 1;
    localparam int CT_CLR_REM = 2;
    localparam int CT_EJECT   = 3;
    localparam int CT_FWEJ    = 4;

    typedef enum logic [1:0] {
        CMD_SCAN   = 2'd0,
        CMD_OST_EV = 2'd1,
        CMD_OST_ST = 2'd2,
        CMD_GET_ID = 2'd3
    } cmd_e;
endpackage

// File: rtl/hp_cell.sv
// Per-processor flag cell: enabled, insert, remove, firmware eject request.
// Assumes ctl_we_i is already qualified by selector validity and match.
module hp_cell
    import hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       add_i,
    input  logic       rem_i,
    input  logic       ctl_we_i,
    input  logic [7:0] ctl_i,
    output logic       en_o,
    output logic       ins_o,
    output logic       rem_o,
    output logic       fwej_o,
    output logic       eject_o
);
    logic clr_ins, clr_rem, set_fw, do_ej;

    // Decode the control byte for this cell
    always_comb begin
        clr_ins = ctl_we_i & ctl_i[CT_CLR_INS];
        clr_rem = ctl_we_i & ctl_i[CT_CLR_REM];
        set_fw  = ctl_we_i & ctl_i[CT_FWEJ];
        do_ej   = ctl_we_i & ctl_i[CT_EJECT];
    end

    // Flag state: requests win over clears, eject clears the firmware request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= 1'b0;
            ins_o   <= 1'b0;
            rem_o   <= 1'b0;
            fwej_o  <= 1'b0;
            eject_o <= 1'b0;
        end else begin
            en_o    <= en_o | add_i;
            ins_o   <= add_i | (ins_o & ~clr_ins);
            rem_o   <= rem_i | (rem_o & ~clr_rem);
            fwej_o  <= (fwej_o | set_fw) & ~do_ej;
            eject_o <= do_ej;
        end
    end
endmodule

// File: rtl/hp_scan.sv
// Lowest-index search over the pending-event vector, purely combinational.
// Assumes IW is wide enough to index N entries.
module hp_scan #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Walk from the top down so the lowest set index is left last
    always_comb begin
        found_o = |pend_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/hp_regwin.sv
// Processor hotplug register window: selector, command, data ports and
// per-processor flags. Assumes one access per cycle with a write strobe
// and a combinational read on bus_addr. The selector has no reset by
// design: it starts at zero at power-up and survives rst_n.
module hp_regwin
    import hp_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [3:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NCPU-1:0]      add_req,
    input  logic [NCPU-1:0]      rem_req,
    input  logic [ID_W*NCPU-1:0] cpu_id,
    output logic [NCPU-1:0]      eject_pulse,
    output logic [31:0]          ost_event,
    output logic [31:0]          ost_status,
    output logic                 ost_notify
);
    localparam int IW = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [31:0]     sel_q = '0;
    cmd_e            cmd_q;
    logic            sel_valid;
    logic [IW-1:0]   sel_idx;
    logic            wr_sel, wr_ctl, wr_cmd, wr_data;
    logic [NCPU-1:0] en_vec, ins_vec, rem_vec, fwej_vec, pend;
    logic            scan_found;
    logic [IW-1:0]   scan_idx;
    logic [ID_W-1:0] ids [NCPU];
    logic [ID_W-1:0] id_sel;
    logic [7:0]      stat_byte;

    // Selector range check and write decode
    always_comb begin
        sel_valid = sel_q < 32'(NCPU);
        sel_idx   = sel_q[IW-1:0];
        wr_sel    = bus_wr && (bus_addr == OFF_SEL);
        wr_ctl    = bus_wr && (bus_addr == OFF_CTL)  && sel_valid;
        wr_cmd    = bus_wr && (bus_addr == OFF_CMD)  && sel_valid;
        wr_data   = bus_wr && (bus_addr == OFF_DATA) && sel_valid;
    end

    // One flag cell per processor, plus its unpacked ID slice
    for (genvar g = 0; g < NCPU; g++) begin : g_cell
        hp_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .add_i    (add_req[g]),
            .rem_i    (rem_req[g]),
            .ctl_we_i (wr_ctl && (sel_idx == IW'(g))),
            .ctl_i    (bus_wdata[7:0]),
            .en_o     (en_vec[g]),
            .ins_o    (ins_vec[g]),
            .rem_o    (rem_vec[g]),
            .fwej_o   (fwej_vec[g]),
            .eject_o  (eject_pulse[g])
        );
        assign ids[g] = cpu_id[g*ID_W +: ID_W];
    end

    assign pend = ins_vec | rem_vec;

    hp_scan #(.N(NCPU), .IW(IW)) u_scan (
        .pend_i  (pend),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    // Selector: direct write, or move onto the search result under command 0
    always_ff @(posedge clk) begin
        if (wr_sel)
            sel_q <= bus_wdata;
        else if (wr_cmd && (bus_wdata[7:0] == 8'd0) && scan_found)
            sel_q <= 32'(scan_idx);
    end

    // Command register: only defined command values are accepted
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= CMD_SCAN;
        else if (wr_cmd && (bus_wdata[7:0] < 8'd4))
            cmd_q <= cmd_e'(bus_wdata[1:0]);
    end

    // Status-report registers and notify pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ost_event  <= '0;
            ost_status <= '0;
            ost_notify <= 1'b0;
        end else begin
            ost_notify <= wr_data && (cmd_q == CMD_OST_ST);
            if (wr_data && (cmd_q == CMD_OST_EV)) ost_event  <= bus_wdata;
            if (wr_data && (cmd_q == CMD_OST_ST)) ost_status <= bus_wdata;
        end
    end

    // Gather the selected processor's ID and status byte
    always_comb begin
        id_sel    = sel_valid ? ids[sel_idx] : '0;
        stat_byte = '0;
        if (sel_valid) begin
            stat_byte[ST_EN]   = en_vec[sel_idx];
            stat_byte[ST_INS]  = ins_vec[sel_idx];
            stat_byte[ST_REM]  = rem_vec[sel_idx];
            stat_byte[ST_FWEJ] = fwej_vec[sel_idx];
        end
    end

    // Read mux: the whole window reads zero while the selector is invalid
    always_comb begin
        bus_rdata = '0;
        if (sel_valid) begin
            case (bus_addr)
                OFF_SEL:  if (cmd_q == CMD_GET_ID) bus_rdata = id_sel[63:32];
                OFF_CTL:  bus_rdata = {24'd0, stat_byte};
                OFF_DATA: begin
                    if (cmd_q == CMD_SCAN)        bus_rdata = sel_q;
                    else if (cmd_q == CMD_GET_ID) bus_rdata = id_sel[31:0];
                end
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hp_regwin_chk.sv
// Checker for hp_regwin, attached with a bind. Observes the bus, the
// selector, the command register and the flag vectors.
module hp_regwin_chk #(
    parameter int NCPU = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [3:0]      bus_addr,
    input logic [31:0]     bus_wdata,
    input logic [NCPU-1:0] add_req,
    input logic [NCPU-1:0] en_vec,
    input logic [NCPU-1:0] pend,
    input logic [NCPU-1:0] eject_pulse,
    input logic            ost_notify,
    input logic [31:0]     sel_q,
    input logic [1:0]      cmd_q
);
    logic sel_ok;
    assign sel_ok = sel_q < 32'(NCPU);

    // R7
    eject_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eject_pulse));

    // R11
    notify_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sel_ok && bus_addr == 4'h8 && cmd_q == 2'd2 |=> ost_notify);

    // R3
    blocked_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !sel_ok && bus_addr != 4'h0 |=> $stable(cmd_q));

    // R8
    scan_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sel_ok && bus_addr == 4'h5 && bus_wdata[7:0] == 8'd0 && (|pend)
        |=> sel_ok && pend[sel_q[$clog2(NCPU)-1:0]]);

    // R9
    scan_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sel_ok && bus_addr == 4'h5 && bus_wdata[7:0] == 8'd0 && !(|pend)
        |=> $stable(sel_q));

    // R5
    add_sets_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|add_req) |=> ((en_vec & $past(add_req)) == $past(add_req)));
endmodule

bind hp_regwin hp_regwin_chk #(.NCPU(NCPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .add_req     (add_req),
    .en_vec      (en_vec),
    .pend        (pend),
    .eject_pulse (eject_pulse),
    .ost_notify  (ost_notify),
    .sel_q       (sel_q),
    .cmd_q       (cmd_q)
);

// File: tb/sim_hp_regwin.sv
// Directed bench for hp_regwin: one task per scenario.
module sim_hp_regwin;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [3:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    add_req = '0;
    logic [N-1:0]    rem_req = '0;
    logic [64*N-1:0] cpu_id;
    logic [N-1:0]    eject_pulse;
    logic [31:0]     ost_event, ost_status;
    logic            ost_notify;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_id
        assign cpu_id[g*64 +: 64] = {32'hA000_0000 + 32'(g), 32'h0000_0100 + 32'(g)};
    end

    hp_regwin #(.NCPU(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .add_req(add_req),
        .rem_req(rem_req), .cpu_id(cpu_id), .eject_pulse(eject_pulse),
        .ost_event(ost_event), .ost_status(ost_status), .ost_notify(ost_notify)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic req_add(input int i);
        @(negedge clk); add_req[i] = 1'b1;
        @(negedge clk); add_req = '0;
    endtask

    task automatic req_rem(input int i);
        @(negedge clk); rem_req[i] = 1'b1;
        @(negedge clk); rem_req = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h8, d); chk("R1 selector zero at power-up", d, 32'd0);
        rd(4'h4, d); chk("R1 flags clear after reset", d, 32'd0);
    endtask

    task automatic t_hotplug;
        logic [31:0] d;
        req_add(5); req_add(2); req_rem(2);
        wr(4'h0, 32'd5);
        rd(4'h4, d); chk("R5 R4 add sets enabled and insert", d, 32'h03);
        wr(4'h0, 32'd2);
        rd(4'h4, d); chk("R5 R4 remove sets remove flag", d, 32'h07);
    endtask

    task automatic t_scan;
        logic [31:0] d;
        wr(4'h0, 32'd7);
        wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R8 search picks lowest pending", d, 32'd2);
        rd(4'h0, d); chk("R8 offset 0 reads zero under command 0", d, 32'd0);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        wr(4'h4, 32'h06);
        rd(4'h4, d); chk("R6 clear insert and remove", d, 32'h01);
        wr(4'h0, 32'd5);
        rd(4'h4, d); chk("R6 other processor untouched", d, 32'h03);
        wr(4'h0, 32'd0);
        wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R8 search finds remaining event", d, 32'd5);
        wr(4'h4, 32'h02);
        rd(4'h4, d); chk("R6 clear insert only", d, 32'h01);
        wr(4'h0, 32'd1);
        wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R9 no pending keeps selector", d, 32'd1);
        wr(4'h0, 32'd5);
        rd(4'h4, d); chk("R9 no pending keeps flags", d, 32'h01);
    endtask

    task automatic t_race;
        logic [31:0] d;
        wr(4'h0, 32'd2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h02; add_req[2] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; add_req = '0;
        rd(4'h4, d); chk("R5 request wins over clear", d, 32'h03);
        wr(4'h4, 32'h02);
    endtask

    task automatic t_eject;
        logic [31:0] d;
        wr(4'h0, 32'd3);
        wr(4'h4, 32'h10);
        rd(4'h4, d); chk("R7 firmware eject request set", d, 32'h10);
        wr(4'h4, 32'h08);
        #1;
        chk("R7 eject pulse on selected bit", 32'(eject_pulse), 32'h08);
        rd(4'h4, d); chk("R7 eject clears firmware request", d, 32'h00);
        @(negedge clk); #1;
        chk("R7 eject pulse lasts one cycle", 32'(eject_pulse), 32'h00);
    endtask

    task automatic t_id;
        logic [31:0] d;
        wr(4'h0, 32'd6);
        wr(4'h5, 32'd3);
        rd(4'h8, d); chk("R10 low ID word", d, 32'h0000_0106);
        rd(4'h0, d); chk("R10 high ID word", d, 32'hA000_0006);
    endtask

    task automatic t_ost;
        logic [31:0] d;
        wr(4'h5, 32'd1);
        wr(4'h8, 32'h11);
        #1;
        chk("R11 event register loaded", ost_event, 32'h11);
        chk("R11 no notify on event load", 32'(ost_notify), 32'd0);
        wr(4'h5, 32'd2);
        wr(4'h8, 32'h22);
        #1;
        chk("R11 status register loaded", ost_status, 32'h22);
        chk("R11 notify pulse", 32'(ost_notify), 32'd1);
        @(negedge clk); #1;
        chk("R11 notify lasts one cycle", 32'(ost_notify), 32'd0);
        rd(4'h8, d); chk("R12 data reads zero under command 2", d, 32'd0);
        rd(4'h0, d); chk("R12 offset 0 reads zero under command 2", d, 32'd0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(4'h5, 32'd3);
        wr(4'h5, 32'd9);
        rd(4'h8, d); chk("R12 reserved command ignored", d, 32'h0000_0106);
        rd(4'h6, d); chk("R12 reserved offset reads zero", d, 32'd0);
        wr(4'h6, 32'hFF);
        rd(4'h8, d); chk("R12 reserved offset write ignored", d, 32'h0000_0106);
        rd(4'h4, d); chk("R12 reserved write leaves status", d, 32'd0);
    endtask

    task automatic t_invalid;
        logic [31:0] d;
        wr(4'h0, 32'(N));
        rd(4'h8, d); chk("R3 invalid selector data reads zero", d, 32'd0);
        rd(4'h4, d); chk("R3 invalid selector status reads zero", d, 32'd0);
        wr(4'h4, 32'h10);
        wr(4'h5, 32'd1);
        wr(4'h0, 32'd6);
        rd(4'h8, d); chk("R3 R2 command write ignored while invalid", d, 32'h0000_0106);
        rd(4'h4, d); chk("R3 control write ignored while invalid", d, 32'd0);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R2 R3 all-ones selector invalid", d, 32'd0);
    endtask

    task automatic t_reset_keep;
        logic [31:0] d;
        wr(4'h0, 32'd4);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(4'h8, d); chk("R1 selector survives reset", d, 32'd4);
        wr(4'h0, 32'd5);
        rd(4'h4, d); chk("R1 reset clears flags", d, 32'd0);
        #1;
        chk("R1 reset clears event register", ost_event, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hotplug();
        t_scan();
        t_clear();
        t_race();
        t_eject();
        t_id();
        t_ost();
        t_reserved();
        t_invalid();
        t_reset_keep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule